// File: doc/BRIEF.md
# ADC External Multiplexer Select Crossbar

This block produces the address lines for external analog multiplexers that sit in front of several ADC instances. Each instance owns a bank of conversion-slot control words. Each word carries a 4-bit external channel code. The code stays in its bank until the slot is triggered. On a trigger, the low two bits of that slot's code are loaded onto the instance's pair of select lines. Each instance has an enable. It also has a timing mode: the lines update either right after the trigger, or after a programmable wait that lines them up with the sampling window.

A crossbar that all instances share drives ten numbered output pins. Each pin has its own route register, and that register picks one select bit from one instance. Software configures everything through a single-cycle register write port and a combinational read port. Conversion triggers arrive on one strobe per instance, each with a slot number beside it.

Top module: `extmux_xbar`

## Requirements
- R1: The external channel code of a slot control word is written from, and read back in, bits 31:28. Slot word address = instance*16 + slot (addresses 0 to 63). All other bits of the word read as zero, and the two upper code bits read back exactly as written.
- R2: Writing a slot control word leaves the select lines and `xbar_out` unchanged until that slot is triggered.
- R3: Only code bits 1:0 reach the select lines. Bit 0 of an instance is its select bit 0 and bit 1 is its select bit 1. Codes above 3 drive their low two bits, so code 13 gives 01 and code 8 gives 00.
- R4: Route register j is at address 64+j and uses bits 3:0. A route code c in the range 0 to 7 drives output j from select bit (c mod 2) of instance c/2. Codes 8 to 15 hold output j low.
- R5: Each trigger replaces the instance's select code with the triggered slot's code. A later slot that holds zero clears bits set by an earlier slot.
- R6: Instances are independent. Triggers on several instances in the same cycle each load that instance's own slot.
- R7: Configuration register for instance i is at address 74+i: bit 0 enable, bit 1 immediate mode, bits 7:4 delay D. While enable is 0, the instance's select lines are zero and its triggers are ignored. After enable returns to 1, the lines stay zero until the next trigger.
- R8: In immediate mode, the select lines take the new code at the same clock edge that samples the trigger.
- R9: In delayed mode, the new code appears max(D,1) clock edges after the edge that samples the trigger. A newer trigger during the wait restarts the wait and replaces the pending code.
- R10: Reset clears all slot words, route registers, configuration registers and select lines, so `xbar_out` reads zero.
- R11: Route and configuration registers read back what was written in their fields. Unmapped addresses (78 to 127) read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| trig | input | 4 | Per-instance conversion trigger strobe |
| trig_slot | input | 16 | Per-instance slot number, 4 bits each, instance 0 in bits 3:0 |
| xbar_out | output | 10 | Crossbar output pins |

## Verification
The assertions assume that `trig_slot` carries a defined slot number in every cycle where its instance's trigger is high. They also assume that reset is applied at the start of the run, before any trigger. The bench drives both trigger inputs to known values at all times and resets before any other activity. The bench never writes a slot word in the same cycle that the same slot is triggered. That write-then-trigger ordering is therefore never relied on, and the assertion that compares a loaded code against the slot bank is never exercised against it.

// File: rtl/extmux_pkg.sv
package extmux_pkg;
    localparam int N_INST     = 4;
    localparam int N_SLOT     = 16;
    localparam int N_OUT      = 10;
    localparam int CODE_W     = 4;
    localparam int ROUTE_W    = 4;
    localparam int DLY_W      = 4;
    localparam int SEL_W      = 2;
    localparam int REG_W      = 32;
    localparam int CODE_LSB   = REG_W - CODE_W;

    localparam int SLOT_W     = $clog2(N_SLOT);
    localparam int INST_W     = $clog2(N_INST);
    localparam int SRC_CNT    = SEL_W * N_INST;
    localparam int SRC_W      = $clog2(SRC_CNT);
    localparam int OUT_IDX_W  = $clog2(N_OUT);
    localparam int SLOT_REGS  = N_INST * N_SLOT;
    localparam int SLOT_IDX_W = $clog2(SLOT_REGS);
    localparam int ROUTE_BASE = SLOT_REGS;
    localparam int CFG_BASE   = ROUTE_BASE + N_OUT;
    localparam int MAP_END    = CFG_BASE + N_INST;
    localparam int ADDR_W     = $clog2(MAP_END);

    localparam logic [ADDR_W-1:0]  ROUTE_BASE_A = ADDR_W'(ROUTE_BASE);
    localparam logic [ADDR_W-1:0]  CFG_BASE_A   = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0]  MAP_END_A    = ADDR_W'(MAP_END);
    localparam logic [ROUTE_W-1:0] SRC_CNT_R    = ROUTE_W'(SRC_CNT);

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             imm;
        logic             en;
    } inst_cfg_t;

    typedef enum logic [1:0] {
        REG_SLOT,
        REG_ROUTE,
        REG_CFG,
        REG_NONE
    } reg_region_t;

    function automatic reg_region_t region_of(logic [ADDR_W-1:0] a);
        if (a < ROUTE_BASE_A) return REG_SLOT;
        if (a < CFG_BASE_A)   return REG_ROUTE;
        if (a < MAP_END_A)    return REG_CFG;
        return REG_NONE;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(inst_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.imm;
        w[4 +: DLY_W] = c.dly;
        return w;
    endfunction

    function automatic inst_cfg_t unpack_cfg(logic [REG_W-1:0] w);
        inst_cfg_t c;
        c.en  = w[0];
        c.imm = w[1];
        c.dly = w[4 +: DLY_W];
        return c;
    endfunction
endpackage

// File: rtl/extmux_regs.sv
module extmux_regs
    import extmux_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [REG_W-1:0]                      wr_data,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [REG_W-1:0]                      rd_data,
    output logic [SLOT_REGS-1:0][CODE_W-1:0]      slot_q,
    output logic [N_OUT-1:0][ROUTE_W-1:0]         route_q,
    output inst_cfg_t [N_INST-1:0]                cfg_q
);
    logic [ADDR_W-1:0] w_route_off, w_cfg_off, r_route_off, r_cfg_off;

    assign w_route_off = wr_addr - ROUTE_BASE_A;
    assign w_cfg_off   = wr_addr - CFG_BASE_A;
    assign r_route_off = rd_addr - ROUTE_BASE_A;
    assign r_cfg_off   = rd_addr - CFG_BASE_A;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            route_q <= '0;
            cfg_q   <= '0;
        end else if (wr_en) begin
            unique case (region_of(wr_addr))
                REG_SLOT:  slot_q[wr_addr[SLOT_IDX_W-1:0]] <= wr_data[CODE_LSB +: CODE_W];
                REG_ROUTE: route_q[w_route_off[OUT_IDX_W-1:0]] <= wr_data[ROUTE_W-1:0];
                REG_CFG:   cfg_q[w_cfg_off[INST_W-1:0]] <= unpack_cfg(wr_data);
                default:   ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (region_of(rd_addr))
            REG_SLOT:  rd_data[CODE_LSB +: CODE_W] = slot_q[rd_addr[SLOT_IDX_W-1:0]];
            REG_ROUTE: rd_data[ROUTE_W-1:0] = route_q[r_route_off[OUT_IDX_W-1:0]];
            REG_CFG:   rd_data = pack_cfg(cfg_q[r_cfg_off[INST_W-1:0]]);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/extmux_seq.sv
module extmux_seq
    import extmux_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  inst_cfg_t                     cfg,
    input  logic                          trig,
    input  logic [SLOT_W-1:0]             trig_slot,
    input  logic [N_SLOT-1:0][CODE_W-1:0] slot_codes,
    output sel_t                          sel,
    output sel_t                          sel_q,
    output logic                          busy
);
    sel_t             pend_q;
    sel_t             code_now;
    logic [DLY_W-1:0] cnt_q;

    assign code_now = slot_codes[trig_slot][SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || !cfg.en) begin
            sel_q  <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
            busy   <= 1'b0;
        end else if (trig) begin
            if (cfg.imm) begin
                sel_q <= code_now;
                busy  <= 1'b0;
            end else begin
                pend_q <= code_now;
                cnt_q  <= cfg.dly;
                busy   <= 1'b1;
            end
        end else if (busy) begin
            if (cnt_q <= DLY_W'(1)) begin
                sel_q <= pend_q;
                busy  <= 1'b0;
            end else begin
                cnt_q <= cnt_q - DLY_W'(1);
            end
        end
    end

    assign sel = cfg.en ? sel_q : '0;
endmodule

// File: rtl/extmux_route.sv
module extmux_route
    import extmux_pkg::*;
(
    input  logic [SRC_CNT-1:0]            src,
    input  logic [N_OUT-1:0][ROUTE_W-1:0] route_q,
    output logic [N_OUT-1:0]              pins
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_pin
        always_comb begin
            if (route_q[j] < SRC_CNT_R) pins[j] = src[route_q[j][SRC_W-1:0]];
            else                        pins[j] = 1'b0;
        end
    end
endmodule

// File: rtl/extmux_xbar.sv
module extmux_xbar
    import extmux_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [REG_W-1:0]         rd_data,
    input  logic [N_INST-1:0]        trig,
    input  logic [N_INST*SLOT_W-1:0] trig_slot,
    output logic [N_OUT-1:0]         xbar_out
);
    logic [SLOT_REGS-1:0][CODE_W-1:0] slot_q;
    logic [N_OUT-1:0][ROUTE_W-1:0]    route_q;
    inst_cfg_t [N_INST-1:0]           cfg_q;
    logic [SRC_CNT-1:0]               sel_flat;
    logic [N_INST-1:0][SEL_W-1:0]     sel_raw;
    logic [N_INST-1:0]                busy_v, en_v, imm_v;

    extmux_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .slot_q  (slot_q),
        .route_q (route_q),
        .cfg_q   (cfg_q)
    );

    for (genvar i = 0; i < N_INST; i++) begin : g_inst
        sel_t sel_g;
        extmux_seq u_seq (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg_q[i]),
            .trig       (trig[i]),
            .trig_slot  (trig_slot[i*SLOT_W +: SLOT_W]),
            .slot_codes (slot_q[i*N_SLOT +: N_SLOT]),
            .sel        (sel_g),
            .sel_q      (sel_raw[i]),
            .busy       (busy_v[i])
        );
        assign sel_flat[i*SEL_W +: SEL_W] = sel_g;
        assign en_v[i]  = cfg_q[i].en;
        assign imm_v[i] = cfg_q[i].imm;
    end

    extmux_route u_route (
        .src     (sel_flat),
        .route_q (route_q),
        .pins    (xbar_out)
    );
endmodule

// File: rtl/extmux_xbar_chk.sv
module extmux_xbar_chk
    import extmux_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_INST-1:0]                trig,
    input  logic [N_INST*SLOT_W-1:0]         trig_slot,
    input  logic [N_OUT-1:0]                 xbar_out,
    input  logic [N_INST-1:0]                en_v,
    input  logic [N_INST-1:0]                imm_v,
    input  logic [N_INST-1:0]                busy_v,
    input  logic [N_INST-1:0][SEL_W-1:0]     sel_raw,
    input  logic [N_OUT-1:0][ROUTE_W-1:0]    route_q,
    input  logic [SLOT_REGS-1:0][CODE_W-1:0] slot_q
);
    logic [N_INST-1:0][SEL_W-1:0] look;

    // R10: reset leaves every pin low
    a_r10_reset_clear: assert property (@(posedge clk) rst |=> (xbar_out == '0));

    for (genvar i = 0; i < N_INST; i++) begin : g_inst_chk
        assign look[i] = slot_q[{INST_W'(i), trig_slot[i*SLOT_W +: SLOT_W]}][SEL_W-1:0];

        // R2: without a trigger or pending load, the select code holds
        a_r2_hold_no_trigger: assert property (@(posedge clk) disable iff (rst)
            (!trig[i] && !busy_v[i] && en_v[i]) |=> $stable(sel_raw[i]));

        // R8: immediate mode loads the triggered slot's low bits
        a_r8_immediate_load: assert property (@(posedge clk) disable iff (rst)
            (trig[i] && en_v[i] && imm_v[i]) |=> (sel_raw[i] == $past(look[i])));
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_pin_chk
        // R4: unused route codes hold the pin low
        a_r4_unused_low: assert property (@(posedge clk) disable iff (rst)
            (route_q[j] >= SRC_CNT_R) |-> !xbar_out[j]);

        // R7: a pin fed by a disabled instance stays low
        a_r7_disabled_low: assert property (@(posedge clk) disable iff (rst)
            ((route_q[j] < SRC_CNT_R) && !en_v[route_q[j][SRC_W-1:1]]) |-> !xbar_out[j]);
    end
endmodule

bind extmux_xbar extmux_xbar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .trig_slot (trig_slot),
    .xbar_out  (xbar_out),
    .en_v      (en_v),
    .imm_v     (imm_v),
    .busy_v    (busy_v),
    .sel_raw   (sel_raw),
    .route_q   (route_q),
    .slot_q    (slot_q)
);

// File: tb/extmux_xbar_test.sv
module extmux_xbar_test;
    localparam int CLK_PERIOD = 10;
    localparam int RB = 64;
    localparam int CB = 74;
    localparam int NV = 8;
    // {instance[9:8], slot[7:4], code[3:0]}
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 4'd1,  4'd2}, {2'd1, 4'd3, 4'd3}, {2'd2, 4'd15, 4'd1}, {2'd3, 4'd0, 4'd13},
        {2'd0, 4'd2,  4'd0}, {2'd1, 4'd5, 4'd7}, {2'd3, 4'd4,  4'd8}, {2'd2, 4'd6, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  trig = '0;
    logic [15:0] trig_slot = '0;
    logic [9:0]  xbar_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] cur [4];
    logic       en_m [4];
    logic [3:0] rt [10];

    extmux_xbar uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trig(trig), .trig_slot(trig_slot),
        .xbar_out(xbar_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] model_out();
        logic [9:0] o;
        for (int j = 0; j < 10; j++) begin
            if (rt[j] < 4'd8) o[j] = en_m[rt[j] >> 1] ? cur[rt[j] >> 1][rt[j][0]] : 1'b0;
            else              o[j] = 1'b0;
        end
        return o;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req);
        #1;
        chk(req, {22'b0, xbar_out}, {22'b0, model_out()});
    endtask

    task automatic chk_rd(string req, int addr, logic [31:0] exp);
        rd_addr = 7'(addr);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr(int addr, logic [31:0] data);
        wr_en = 1'b1; wr_addr = 7'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(int inst, int slot);
        trig[inst] = 1'b1;
        trig_slot[inst*4 +: 4] = 4'(slot);
        @(negedge clk);
        trig = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin cur[i] = '0; en_m[i] = 1'b0; end
        for (int j = 0; j < 10; j++) rt[j] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 pins after reset", {22'b0, xbar_out}, 32'h0);
        chk_rd("R10 slot word after reset", 37, 32'h0);
        chk_rd("R10 route after reset", RB + 3, 32'h0);
        chk_rd("R10 config after reset", CB + 2, 32'h0);

        // setup: routes 0..7 direct, pin 8 unused code, pin 9 = instance 0 bit 1
        for (int j = 0; j < 8; j++) begin wr(RB + j, 32'(j)); rt[j] = 4'(j); end
        wr(RB + 8, 32'hF); rt[8] = 4'hF;
        wr(RB + 9, 32'h1); rt[9] = 4'h1;
        for (int i = 0; i < 4; i++) begin wr(CB + i, 32'h3); en_m[i] = 1'b1; end
        chk_rd("R11 route readback", RB + 9, 32'h1);
        chk_rd("R11 route readback unused code", RB + 8, 32'hF);
        chk_rd("R11 config readback", CB + 0, 32'h3);

        // R1: field placement and readback
        wr(9, 32'hD000_ABCD);
        chk_rd("R1 code in bits 31:28 only", 9, 32'hD000_0000);

        // vector table: R2 before trigger, R3/R5/R8 after
        for (int v = 0; v < NV; v++) begin
            int inst, slot;
            logic [3:0] code;
            inst = int'(VEC[v][9:8]); slot = int'(VEC[v][7:4]); code = VEC[v][3:0];
            wr(inst*16 + slot, {code, 28'h0});
            chk_out("R2 write alone does not move pins");
            chk_rd("R1 table readback", inst*16 + slot, {code, 28'h0});
            fire(inst, slot);
            cur[inst] = code[1:0];
            chk_out(code > 4'd3 ? "R3 upper code bits ignored" : "R5 R8 slot code on pins");
        end

        // R6: two instances in the same cycle
        trig = 4'b1001;
        trig_slot = {4'd0, 4'd0, 4'd0, 4'd1};
        @(negedge clk);
        trig = '0;
        cur[0] = 2'd2; cur[3] = 2'd1;
        chk_out("R6 simultaneous triggers");

        // R2: rewrite a fired slot, no trigger
        wr(1, 32'h1000_0000);
        repeat (3) @(negedge clk);
        chk_out("R2 pins hold after rewrite");
        fire(0, 1); cur[0] = 2'd1;
        chk_out("R2 new code after trigger");
        fire(0, 2); cur[0] = 2'd0;
        chk_out("R5 zero slot clears bits");

        // R7: disable instance 1
        wr(CB + 1, 32'h2); en_m[1] = 1'b0;
        chk_out("R7 disabled lines zero");
        fire(1, 3);
        chk_out("R7 trigger ignored while disabled");
        wr(CB + 1, 32'h3); en_m[1] = 1'b1; cur[1] = 2'd0;
        chk_out("R7 lines stay zero after re-enable");
        fire(1, 3); cur[1] = 2'd3;
        chk_out("R7 trigger works after re-enable");

        // R9: delayed mode, D = 3, instance 2 (cur[2] = 2)
        wr(CB + 2, 32'h31);
        wr(2*16 + 7, 32'h1000_0000);
        wr(2*16 + 8, 32'h3000_0000);
        wr(2*16 + 10, 32'h2000_0000);
        fire(2, 7);
        chk_out("R9 delay edge 1 old value");
        @(negedge clk); chk_out("R9 delay edge 2 old value");
        @(negedge clk); chk_out("R9 delay edge 3 minus one old value");
        @(negedge clk); cur[2] = 2'd1; chk_out("R9 code after D edges");
        fire(2, 8);
        @(negedge clk);
        fire(2, 10);
        @(negedge clk); chk_out("R9 restart hides first pending code");
        @(negedge clk); chk_out("R9 restart still waiting");
        @(negedge clk); cur[2] = 2'd2; chk_out("R9 restarted code appears");
        // D = 0 behaves as one edge
        wr(CB + 2, 32'h01);
        fire(2, 8);
        chk_out("R9 D=0 not yet");
        @(negedge clk); cur[2] = 2'd3; chk_out("R9 D=0 after one edge");

        // R4: retarget pin 9 to an unused code, then to instance 2 bit 0
        wr(RB + 9, 32'h9); rt[9] = 4'h9;
        chk_out("R4 unused route code low");
        wr(RB + 9, 32'h4); rt[9] = 4'h4;
        chk_out("R4 route to instance 2 bit 0");

        // R11: unmapped address
        wr(127, 32'hFFFF_FFFF);
        chk_rd("R11 unmapped reads zero", 127, 32'h0);
        chk_rd("R11 unmapped write leaves route", RB + 0, 32'h0);
        chk_out("R11 unmapped write leaves pins");

        // R10: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 pins after second reset", {22'b0, xbar_out}, 32'h0);
        chk_rd("R10 slot cleared", 2*16 + 8, 32'h0);
        chk_rd("R10 config cleared", CB + 2, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule